// File: doc/BRIEF.md
# Key-Unlocked Configuration Register Bank

This block is a small bank of memory-mapped control and status words that sits on a plain 32-bit register bus. The bus has a byte address, write data, a write strobe, a read strobe and registered read data. The contents of the configuration words drive output ports directly, so other logic on the chip sees each setting as soon as it is accepted.

Most words are protected. A write to one of them only takes effect after software has placed two fixed keys, in a fixed order, into two kick words. The device-control word has an extra guard: its own lock word must also hold a third key. One word takes a single write after reset. Another word is write-once bit by bit. An identification word is read-only.

A write that the protection rejects is dropped without any change to the bank, and the error output pulses for one cycle. Reads are allowed at all times, whether the bank is locked or not.

Top module: `keyed_cfg_bank`

## Requirements
- R1: After reset the bank is locked and `err_o` is 0. The device-control, once, bit-once, general and lock words are all 0. The privilege word is 0xAAAAAAAA.
- R2: Writing 0x83E70B13 to offset 0x038 and then 0x95A4F1E0 to offset 0x03C unlocks the bank. `unlocked_o` goes high in the cycle after the second write. A read of either kick offset returns the unlock state in bit 0 and zeros elsewhere.
- R3: While the bank is not yet open, three writes return it to fully locked: a wrong value to either kick offset, the second key written before the first, or the second key written to the first kick offset.
- R4: While the bank is open, writing any non-key value to either kick offset locks it again. Rewriting the correct key to its own kick offset keeps the bank open.
- R5: The protected offsets are 0x004, 0x008, 0x00C, 0x010, 0x014 and 0x41C. A write to any of them while the bank is locked is dropped, and `err_o` is 1 for exactly the following cycle.
- R6: A write to the device-control word at 0x008 also requires the lock word at 0x004 to hold 0x0F0A0B00. Otherwise the write is dropped and `err_o` pulses.
- R7: The device-control word holds twelve 2-bit device fields at bits 23:0 and one more 2-bit field at bits 31:30. Bits 29:24 always read as 0.
- R8: The field at bits 31:30 belongs to a device that cannot be disabled. An accepted write of 2'b00 to that field leaves it unchanged, while any other value is stored.
- R9: The word at 0x00C stores only the first write accepted after reset. Later writes are ignored until the next reset.
- R10: The word at 0x010 is write-once per bit. In a write, wdata[31:16] selects the bits to set and wdata[15:0] gives their values. Each selected bit that has not been written before takes its value and sets a sticky flag. A read returns the flags in [31:16] and the values in [15:0].
- R11: The word at 0x000 is read-only and reads as 0x26C0A51D: revision 0x2 in bits 31:28 and device code 0x6C0A51D below it. A write to it changes nothing and raises no error.
- R12: The privilege word at 0x41C and the general word at 0x014 are freely writable while the bank is open.
- R13: When `re` is high in a cycle, `rdata` returns the word as it stood before that cycle's write, one cycle later. Without `re`, `rdata` holds its value. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 12 | Byte address of the access |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe |
| re | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| err_o | output | 1 | One-cycle pulse for each dropped protected write |
| unlocked_o | output | 1 | High while the key sequence has opened the bank |
| devctl_o | output | 32 | Device-control word |
| once_cfg_o | output | 32 | Single-write configuration word |
| bit_cfg_o | output | 16 | Values of the per-bit write-once word |
| gen_cfg_o | output | 32 | General configuration word |
| priv_o | output | 32 | Privilege word |

## Verification
The hardest case to reach combines three conditions at once: a device-control write that passes the kick sequence but still fails the lock-word key. A second hard case is the bank re-locking after partial progress through the sequence. To reach these, the stimulus walks the kick words through each wrong order and each wrong value, and it opens the bank both with and without the lock key. It then closes the bank with a stray kick write and repeats the protected writes. The write-once words are written again after a mid-run reset to show that only reset re-arms them.

// File: rtl/keyed_cfg_pkg.sv
`timescale 1ns/1ps
package keyed_cfg_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // Offsets of the bank words
    localparam addr_t OFS_ID     = 12'h000;
    localparam addr_t OFS_LOCK   = 12'h004;
    localparam addr_t OFS_DEVCTL = 12'h008;
    localparam addr_t OFS_ONCE   = 12'h00C;
    localparam addr_t OFS_BITS   = 12'h010;
    localparam addr_t OFS_GEN    = 12'h014;
    localparam addr_t OFS_KICK0  = 12'h038;
    localparam addr_t OFS_KICK1  = 12'h03C;
    localparam addr_t OFS_PRIV   = 12'h41C;

    // Keys and reset values
    localparam word_t KICK_KEY0  = 32'h83E70B13;
    localparam word_t KICK_KEY1  = 32'h95A4F1E0;
    localparam word_t LOCK_KEY   = 32'h0F0A0B00;
    localparam word_t PRIV_RESET = 32'hAAAAAAAA;

    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_HALF   = 2'd1,
        KS_OPEN   = 2'd2
    } kick_st_e;

    typedef struct packed {
        kick_st_e st;
    } kick_regs_t;

    typedef struct packed {
        word_t lock;
        word_t devctl;
        word_t once_val;
        logic  once_used;
        word_t gen;
        word_t priv;
        word_t rdata;
        logic  err;
    } bank_regs_t;
endpackage

// File: rtl/keyed_cfg_kick.sv
`timescale 1ns/1ps
module keyed_cfg_kick
    import keyed_cfg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_k0,
    input  logic  wr_k1,
    input  word_t wdata,
    output logic  unlocked
);
    kick_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_k0) begin
            // first key: advance from locked, keep later stages, else relock
            if (wdata != KICK_KEY0) begin
                r_d.st = KS_LOCKED;
            end else if (r_q.st == KS_LOCKED) begin
                r_d.st = KS_HALF;
            end
        end else if (wr_k1) begin
            // second key only counts after the first
            if (wdata == KICK_KEY1 && r_q.st != KS_LOCKED) begin
                r_d.st = KS_OPEN;
            end else begin
                r_d.st = KS_LOCKED;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st <= KS_LOCKED;
        end else begin
            r_q <= r_d;
        end
    end

    assign unlocked = (r_q.st == KS_OPEN);
endmodule

// File: rtl/keyed_cfg_devfield.sv
`timescale 1ns/1ps
module keyed_cfg_devfield #(
    parameter int FIELD_W = 2,
    parameter bit NO_DIS  = 1'b0
) (
    input  logic [FIELD_W-1:0] cur,
    input  logic [FIELD_W-1:0] req,
    input  logic               wr,
    output logic [FIELD_W-1:0] nxt
);
    logic clear_blocked;

    always_comb begin
        clear_blocked = NO_DIS && (req == '0);
        nxt = cur;
        if (wr && !clear_blocked) begin
            nxt = req;
        end
    end
endmodule

// File: rtl/keyed_cfg_bitonce.sv
`timescale 1ns/1ps
module keyed_cfg_bitonce #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] sel,
    input  logic [W-1:0] val,
    output logic [W-1:0] val_q,
    output logic [W-1:0] flag_q
);
    typedef struct packed {
        logic [W-1:0] val;
        logic [W-1:0] flag;
    } bo_regs_t;

    bo_regs_t r_d, r_q;
    logic [W-1:0] take;

    always_comb begin
        r_d  = r_q;
        take = wr ? (sel & ~r_q.flag) : '0;
        r_d.val  = (r_q.val & ~take) | (val & take);
        r_d.flag = r_q.flag | take;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign val_q  = r_q.val;
    assign flag_q = r_q.flag;
endmodule

// File: rtl/keyed_cfg_bank.sv
`timescale 1ns/1ps
module keyed_cfg_bank
    import keyed_cfg_pkg::*;
#(
    parameter int          N_DEV      = 13,
    parameter int          FIELD_W    = 2,
    parameter logic [12:0] NODIS_MASK = 13'h1000,
    parameter int          ONCE_W     = 16,
    parameter logic [3:0]  SI_REV     = 4'h2,
    parameter logic [27:0] DEV_CODE   = 28'h6C0A51D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic              re,
    output logic [DATA_W-1:0] rdata,
    output logic              err_o,
    output logic              unlocked_o,
    output logic [DATA_W-1:0] devctl_o,
    output logic [DATA_W-1:0] once_cfg_o,
    output logic [ONCE_W-1:0] bit_cfg_o,
    output logic [DATA_W-1:0] gen_cfg_o,
    output logic [DATA_W-1:0] priv_o
);
    localparam int    FLD_BITS = N_DEV * FIELD_W;
    localparam word_t ID_WORD  = {SI_REV, DEV_CODE};

    // lowest bit of device field i: all but the last are packed from bit 0,
    // the last sits at the top of the word
    function automatic int fld_lsb(input int i);
        return (i == N_DEV - 1) ? (DATA_W - FIELD_W) : (i * FIELD_W);
    endfunction

    bank_regs_t r_d, r_q;

    logic              unlocked;
    logic              hit_id, hit_lock, hit_dev, hit_once, hit_bits;
    logic              hit_gen, hit_k0, hit_k1, hit_priv, hit_prot;
    logic              key_ok, drop, wr_ok, dev_wr, bits_wr;
    logic [FLD_BITS-1:0] fld_nxt;
    word_t             dev_word;
    word_t             rd_val;
    logic [ONCE_W-1:0] bit_val, bit_flags;

    // address decode
    always_comb begin
        hit_id   = (addr == OFS_ID);
        hit_lock = (addr == OFS_LOCK);
        hit_dev  = (addr == OFS_DEVCTL);
        hit_once = (addr == OFS_ONCE);
        hit_bits = (addr == OFS_BITS);
        hit_gen  = (addr == OFS_GEN);
        hit_k0   = (addr == OFS_KICK0);
        hit_k1   = (addr == OFS_KICK1);
        hit_priv = (addr == OFS_PRIV);
        hit_prot = hit_lock | hit_dev | hit_once | hit_bits | hit_gen | hit_priv;
        key_ok   = (r_q.lock == LOCK_KEY);
        drop     = we && hit_prot && (!unlocked || (hit_dev && !key_ok));
        wr_ok    = we && unlocked;
        dev_wr   = wr_ok && hit_dev && key_ok;
        bits_wr  = wr_ok && hit_bits;
    end

    keyed_cfg_kick u_kick (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_k0    (we && hit_k0),
        .wr_k1    (we && hit_k1),
        .wdata    (wdata),
        .unlocked (unlocked)
    );

    for (genvar g = 0; g < N_DEV; g++) begin : g_fld
        localparam int LSB = fld_lsb(g);
        keyed_cfg_devfield #(
            .FIELD_W (FIELD_W),
            .NO_DIS  (NODIS_MASK[g])
        ) u_fld (
            .cur (r_q.devctl[LSB +: FIELD_W]),
            .req (wdata[LSB +: FIELD_W]),
            .wr  (dev_wr),
            .nxt (fld_nxt[g*FIELD_W +: FIELD_W])
        );
    end

    keyed_cfg_bitonce #(
        .W (ONCE_W)
    ) u_bits (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bits_wr),
        .sel    (wdata[ONCE_W +: ONCE_W]),
        .val    (wdata[ONCE_W-1:0]),
        .val_q  (bit_val),
        .flag_q (bit_flags)
    );

    // reassemble device word, reserved bits forced to zero
    always_comb begin
        dev_word = '0;
        for (int i = 0; i < N_DEV; i++) begin
            dev_word[fld_lsb(i) +: FIELD_W] = fld_nxt[i*FIELD_W +: FIELD_W];
        end
    end

    // read mux
    always_comb begin
        rd_val = '0;
        if (hit_id)   rd_val = ID_WORD;
        if (hit_lock) rd_val = r_q.lock;
        if (hit_dev)  rd_val = r_q.devctl;
        if (hit_once) rd_val = r_q.once_val;
        if (hit_bits) begin
            rd_val[ONCE_W-1:0]      = bit_val;
            rd_val[ONCE_W +: ONCE_W] = bit_flags;
        end
        if (hit_gen)  rd_val = r_q.gen;
        if (hit_k0 || hit_k1) rd_val = {{(DATA_W-1){1'b0}}, unlocked};
        if (hit_priv) rd_val = r_q.priv;
    end

    // next state
    always_comb begin
        r_d        = r_q;
        r_d.err    = drop;
        r_d.devctl = dev_word;
        if (re) begin
            r_d.rdata = rd_val;
        end
        if (wr_ok && hit_lock) begin
            r_d.lock = wdata;
        end
        if (wr_ok && hit_once && !r_q.once_used) begin
            r_d.once_val  = wdata;
            r_d.once_used = 1'b1;
        end
        if (wr_ok && hit_gen) begin
            r_d.gen = wdata;
        end
        if (wr_ok && hit_priv) begin
            r_d.priv = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.priv <= PRIV_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign rdata      = r_q.rdata;
    assign err_o      = r_q.err;
    assign unlocked_o = unlocked;
    assign devctl_o   = r_q.devctl;
    assign once_cfg_o = r_q.once_val;
    assign bit_cfg_o  = bit_val;
    assign gen_cfg_o  = r_q.gen;
    assign priv_o     = r_q.priv;
endmodule

// File: rtl/keyed_cfg_chk.sv
`timescale 1ns/1ps
module keyed_cfg_chk
    import keyed_cfg_pkg::*;
#(
    parameter int FIELD_W = 2,
    parameter int ONCE_W  = 16,
    parameter bit NO_DIS  = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               we,
    input logic [ADDR_W-1:0]  addr,
    input logic [DATA_W-1:0]  wdata,
    input logic               unlocked,
    input logic               err,
    input logic [DATA_W-1:0]  priv,
    input logic [FIELD_W-1:0] top_field,
    input logic               once_used,
    input logic [DATA_W-1:0]  once_val,
    input logic [ONCE_W-1:0]  flags
);
    AST_UNLOCK_AFTER_KEY1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(we && addr == OFS_KICK1 && wdata == KICK_KEY1)); // R2

    AST_RELOCK_ON_BAD_KICK: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFS_KICK0 && wdata != KICK_KEY0) |=> !unlocked); // R4

    AST_ERR_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(we)); // R5

    AST_PRIV_HELD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(priv)); // R12

    AST_NODIS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (NO_DIS && top_field != '0) |=> (top_field != '0)); // R8

    AST_ONCE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        once_used |=> (once_used && $stable(once_val))); // R9

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((flags & $past(flags)) == $past(flags))); // R10
endmodule

bind keyed_cfg_bank keyed_cfg_chk #(
    .FIELD_W (FIELD_W),
    .ONCE_W  (ONCE_W),
    .NO_DIS  (NODIS_MASK[N_DEV-1])
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (we),
    .addr      (addr),
    .wdata     (wdata),
    .unlocked  (unlocked_o),
    .err       (err_o),
    .priv      (priv_o),
    .top_field (devctl_o[DATA_W-1 -: FIELD_W]),
    .once_used (r_q.once_used),
    .once_val  (r_q.once_val),
    .flags     (bit_flags)
);

// File: tb/keyed_cfg_bank_tb.sv
`timescale 1ns/1ps
module keyed_cfg_bank_tb;
    import keyed_cfg_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic [31:0] rdata, devctl_o, once_cfg_o, gen_cfg_o, priv_o;
    logic [15:0] bit_cfg_o;
    logic        err_o, unlocked_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit live    = 1'b0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    keyed_cfg_bank u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we), .re(re),
        .rdata(rdata), .err_o(err_o), .unlocked_o(unlocked_o), .devctl_o(devctl_o),
        .once_cfg_o(once_cfg_o), .bit_cfg_o(bit_cfg_o), .gen_cfg_o(gen_cfg_o),
        .priv_o(priv_o)
    );

    // behavioural reference state
    int          m_ks;
    logic [31:0] m_lock, m_dev, m_once, m_gen, m_priv, m_rd;
    bit          m_once_used, m_err;
    logic [15:0] m_bval, m_bflag;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_ks = 0; m_lock = '0; m_dev = '0; m_once = '0; m_once_used = 0;
        m_gen = '0; m_priv = 32'hAAAAAAAA; m_rd = '0; m_err = 0;
        m_bval = '0; m_bflag = '0;
    endtask

    function automatic logic [31:0] mread(input logic [11:0] a);
        case (a)
            12'h000: return 32'h26C0A51D;
            12'h004: return m_lock;
            12'h008: return m_dev;
            12'h00C: return m_once;
            12'h010: return {m_bflag, m_bval};
            12'h014: return m_gen;
            12'h038, 12'h03C: return {31'd0, m_ks == 2};
            12'h41C: return m_priv;
            default: return 32'h0;
        endcase
    endfunction

    task automatic step(input bit w, input bit r, input logic [11:0] a,
                        input logic [31:0] d);
        bit prot, drop;
        logic [31:0] rv;
        rv   = mread(a);
        prot = (a == 12'h004) || (a == 12'h008) || (a == 12'h00C) ||
               (a == 12'h010) || (a == 12'h014) || (a == 12'h41C);
        drop = w && prot && ((m_ks != 2) || (a == 12'h008 && m_lock != 32'h0F0A0B00));
        m_err = drop;
        if (r) m_rd = rv;
        if (w && !drop && prot) begin
            if (a == 12'h004) m_lock = d;
            if (a == 12'h014) m_gen = d;
            if (a == 12'h41C) m_priv = d;
            if (a == 12'h00C && !m_once_used) begin m_once = d; m_once_used = 1; end
            if (a == 12'h010) begin
                for (int i = 0; i < 16; i++) begin
                    if (d[16+i] && !m_bflag[i]) begin m_bflag[i] = 1; m_bval[i] = d[i]; end
                end
            end
            if (a == 12'h008) begin
                for (int i = 0; i < 13; i++) begin
                    int p;
                    p = (i == 12) ? 30 : 2 * i;
                    if (!(i == 12 && d[p +: 2] == 2'b00)) m_dev[p +: 2] = d[p +: 2];
                end
            end
        end
        if (w && a == 12'h038) begin
            if (d != 32'h83E70B13) m_ks = 0;
            else if (m_ks == 0) m_ks = 1;
        end
        if (w && a == 12'h03C) begin
            m_ks = (d == 32'h95A4F1E0 && m_ks != 0) ? 2 : 0;
        end
    endtask

    task automatic cyc(input bit w, input bit r, input logic [11:0] a, input logic [31:0] d);
        we = w; re = r; addr = a; wdata = d;
        @(posedge clk); #1;
        step(w, r, a, d);
        we = 1'b0; re = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d); cyc(1, 0, a, d); endtask
    task automatic rd(input logic [11:0] a); cyc(0, 1, a, 32'h0); endtask

    task automatic do_reset();
        live = 1'b0;
        rst_n = 1'b0;
        model_reset();
        repeat (2) begin @(posedge clk); #1; end
        rst_n = 1'b1;
        live = 1'b1;
    endtask

    task automatic open_bank();
        wr(12'h038, 32'h83E70B13);
        wr(12'h03C, 32'h95A4F1E0);
    endtask

    // per-cycle comparison against the model, mid-cycle
    always @(negedge clk) begin
        if (live && rst_n && !done) begin
            check(unlocked_o === (m_ks == 2), "R2", {31'd0, unlocked_o}, {31'd0, m_ks == 2});
            check(err_o === m_err, "R5", {31'd0, err_o}, {31'd0, m_err});
            check(devctl_o === m_dev, "R7", devctl_o, m_dev);
            check(once_cfg_o === m_once, "R9", once_cfg_o, m_once);
            check(bit_cfg_o === m_bval, "R10", {16'd0, bit_cfg_o}, {16'd0, m_bval});
            check(gen_cfg_o === m_gen, "R12", gen_cfg_o, m_gen);
            check(priv_o === m_priv, "R12", priv_o, m_priv);
            check(rdata === m_rd, "R13", rdata, m_rd);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        @(posedge clk); #1;
        do_reset();
        // R1 reset state
        check(!unlocked_o && !err_o && devctl_o == 0 && once_cfg_o == 0 && gen_cfg_o == 0,
              "R1", {31'd0, unlocked_o}, 32'h0);
        check(priv_o === 32'hAAAAAAAA, "R1", priv_o, 32'hAAAAAAAA);

        // R11 ID word, read-only
        rd(12'h000);
        check(rdata === 32'h26C0A51D, "R11", rdata, 32'h26C0A51D);
        wr(12'h000, 32'h0);
        check(err_o === 1'b0, "R11", {31'd0, err_o}, 32'h0);
        rd(12'h000);
        check(rdata === 32'h26C0A51D, "R11", rdata, 32'h26C0A51D);

        // R5 locked writes dropped
        wr(12'h014, 32'h12345678);
        check(err_o === 1'b1 && gen_cfg_o === 32'h0, "R5", gen_cfg_o, 32'h0);
        cyc(0, 0, 12'h0, 32'h0);
        check(err_o === 1'b0, "R5", {31'd0, err_o}, 32'h0);
        wr(12'h41C, 32'h0);
        check(priv_o === 32'hAAAAAAAA, "R5", priv_o, 32'hAAAAAAAA);

        // R3 wrong orders and values
        wr(12'h03C, 32'h95A4F1E0);
        wr(12'h038, 32'h83E70B13);
        wr(12'h038, 32'h83E70B12);
        wr(12'h03C, 32'h95A4F1E0);
        check(unlocked_o === 1'b0, "R3", {31'd0, unlocked_o}, 32'h0);
        wr(12'h038, 32'h83E70B13);
        wr(12'h038, 32'h95A4F1E0);
        wr(12'h03C, 32'h95A4F1E0);
        check(unlocked_o === 1'b0, "R3", {31'd0, unlocked_o}, 32'h0);

        // R2 correct sequence
        wr(12'h038, 32'h83E70B13);
        check(unlocked_o === 1'b0, "R2", {31'd0, unlocked_o}, 32'h0);
        wr(12'h03C, 32'h95A4F1E0);
        check(unlocked_o === 1'b1, "R2", {31'd0, unlocked_o}, 32'h1);
        rd(12'h038);
        check(rdata === 32'h1, "R2", rdata, 32'h1);
        wr(12'h038, 32'h83E70B13);
        check(unlocked_o === 1'b1, "R4", {31'd0, unlocked_o}, 32'h1);

        // R12 general and privilege words
        wr(12'h014, 32'hCAFEF00D);
        wr(12'h41C, 32'h55550000);
        rd(12'h41C);
        check(rdata === 32'h55550000, "R12", rdata, 32'h55550000);

        // R6 device control needs lock key
        wr(12'h008, 32'hFFFFFFFF);
        check(err_o === 1'b1 && devctl_o === 32'h0, "R6", devctl_o, 32'h0);
        wr(12'h004, 32'h0F0A0B00);
        wr(12'h008, 32'hFFFFFFFF);
        check(devctl_o === 32'hC0FFFFFF, "R7", devctl_o, 32'hC0FFFFFF);
        wr(12'h008, 32'h0);
        check(devctl_o === 32'hC0000000, "R8", devctl_o, 32'hC0000000);
        wr(12'h008, 32'h40000005);
        check(devctl_o === 32'h40000005, "R8", devctl_o, 32'h40000005);

        // R13 read-before-write, hold, unmapped
        cyc(1, 1, 12'h014, 32'h00000001);
        check(rdata === 32'hCAFEF00D, "R13", rdata, 32'hCAFEF00D);
        cyc(0, 0, 12'h0, 32'h0);
        check(rdata === 32'hCAFEF00D, "R13", rdata, 32'hCAFEF00D);
        rd(12'h100);
        check(rdata === 32'h0, "R13", rdata, 32'h0);

        // R9 single write
        wr(12'h00C, 32'h00001234);
        wr(12'h00C, 32'h00005678);
        check(once_cfg_o === 32'h00001234, "R9", once_cfg_o, 32'h00001234);

        // R10 per-bit write once
        wr(12'h010, 32'h00FF00A5);
        wr(12'h010, 32'hFFFFFFFF);
        check(bit_cfg_o === 16'hFFA5, "R10", {16'd0, bit_cfg_o}, 32'h0000FFA5);
        rd(12'h010);
        check(rdata === 32'hFFFFFFA5, "R10", rdata, 32'hFFFFFFA5);

        // R4 relock via bad kick writes
        wr(12'h038, 32'h0);
        check(unlocked_o === 1'b0, "R4", {31'd0, unlocked_o}, 32'h0);
        wr(12'h014, 32'h77777777);
        check(gen_cfg_o === 32'h00000001, "R4", gen_cfg_o, 32'h00000001);
        open_bank();
        wr(12'h03C, 32'h1);
        check(unlocked_o === 1'b0, "R4", {31'd0, unlocked_o}, 32'h0);

        // reset re-arms write-once words
        do_reset();
        check(once_cfg_o === 32'h0 && priv_o === 32'hAAAAAAAA, "R1", once_cfg_o, 32'h0);
        open_bank();
        wr(12'h00C, 32'h0000ABCD);
        check(once_cfg_o === 32'h0000ABCD, "R9", once_cfg_o, 32'h0000ABCD);
        wr(12'h010, 32'h00010000);
        wr(12'h010, 32'h00010001);
        check(bit_cfg_o === 16'h0000, "R10", {16'd0, bit_cfg_o}, 32'h0);
        repeat (3) cyc(0, 0, 12'h0, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule